// File: doc/BRIEF.md
# Vector Halfword Multiply-Sum Saturating Unit

This block is an execution datapath for a vector unit. It takes three 128-bit operands, A, B and C, and treats each of them as four 32-bit lanes. In every lane, each of the two signed 16-bit halfwords of A is multiplied by the halfword of B in the same position. The two products are added to the signed 32-bit lane word of C. The total is clamped to the signed 32-bit range and written to the matching lane of the 128-bit result.

The unit decodes the instruction word that comes with the operands. It acts only on the matching multiply-sum encoding, and it registers its result one cycle after issue. A sticky saturation flag records that some lane was clamped, and only an explicit status write changes it. When the vector facility is disabled, the unit computes nothing. It raises a one-cycle fault pulse instead, and its result and flag stay as they were.

Top module: `vmsum_unit`

## Requirements
- R1: For each lane k (bits 32k+31..32k), the result is C.k + A.k[15:0]·B.k[15:0] + A.k[31:16]·B.k[31:16]. All values are signed two's complement, and the computed total is exact.
- R2: A lane total above 0x7FFFFFFF yields 0x7FFFFFFF. A lane total below -2^31 yields 0x80000000.
- R3: The lane sum is formed at full width before clamping. One product of (-32768)×(-32768) = 0x40000000 does not clamp on its own. Two such products with a non-negative accumulator do clamp.
- R4: The saturation flag `sat_o` is set when any lane of an executed operation clamps. An executed operation that does not clamp leaves it unchanged.
- R5: A status write (`sat_wr_i`=1) loads `sat_wdata_i` into the flag. If a clamp happens in the same cycle, the flag reads 1 afterwards.
- R6: An issue with a matching instruction while `vec_en_i`=0 gives `fault_o`=1 for one cycle. It leaves `res_valid_o` at 0 and keeps both `res_o` and `sat_o` unchanged.
- R7: An issue executes only if insn_i[31:26]=4 and insn_i[5:0]=41. Any other word raises no fault, produces no valid result and leaves `res_o` unchanged.
- R8: The result appears one cycle after issue. In that cycle `res_valid_o` is 1 and `res_vd_o` carries insn_i[25:21] from the issue cycle.
- R9: After reset, `res_o`=0, `res_valid_o`=0, `fault_o`=0 and `sat_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Operation issued this cycle |
| vec_en_i | input | 1 | Vector facility enabled |
| insn_i | input | 32 | Instruction word for decode |
| opa_i | input | 128 | Operand A (halfword multiplicands) |
| opb_i | input | 128 | Operand B (halfword multipliers) |
| opc_i | input | 128 | Operand C (32-bit accumulators) |
| sat_wr_i | input | 1 | Status write strobe for the saturation flag |
| sat_wdata_i | input | 1 | Value written to the saturation flag |
| res_o | output | 128 | Registered lane results |
| res_valid_o | output | 1 | Result written this cycle |
| res_vd_o | output | 5 | Destination register field of the result |
| fault_o | output | 1 | Vector-unavailable fault pulse |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Every cycle, the assertions check four things. A clamped lane holds exactly one of the two bounds. The flag rises only after a clamp or a status write, and it falls only after a write. A fault leaves the result and the flag as they were. A non-matching or idle cycle changes nothing. Only the bench scenarios can show that the lane arithmetic is correct: the exact sums for mixed signs, the single most-negative product that stays unclamped, and clamping in both directions. The same holds for the destination field, for a write and a clamp arriving in the same cycle, and for rejection of words that match only one opcode field.

// File: rtl/vmsum_pkg.sv
// Package: shared widths, opcode constants and decoded-field type for the
// vector multiply-sum unit. Assumes two halfwords per lane word.
package vmsum_pkg;
    parameter int LANES = 4;
    parameter int HW    = 16;
    localparam int WORD = 2 * HW;
    localparam int VEC  = LANES * WORD;
    localparam int SUMW = WORD + 2;

    localparam logic [5:0] OPC_PRIMARY = 6'd4;
    localparam logic [5:0] OPC_EXT     = 6'd41;

    typedef struct packed {
        logic [4:0] vd;
        logic [4:0] va;
        logic [4:0] vb;
        logic [4:0] vc;
    } vmsum_fields_t;
endpackage

// File: rtl/vmsum_decode.sv
// Module: vmsum_decode
// Recognises the multiply-sum encoding and splits out its register fields.
// Assumes bit 31 of the word is the most significant opcode bit.
module vmsum_decode
    import vmsum_pkg::*;
(
    input  logic [31:0]   insn_i,
    output logic          match_o,
    output vmsum_fields_t fields_o
);
    // Compare both opcode fields against the multiply-sum code points.
    always_comb begin
        match_o = (insn_i[31:26] == OPC_PRIMARY) && (insn_i[5:0] == OPC_EXT);
    end

    // Pull out the four register specifiers.
    always_comb begin
        fields_o.vd = insn_i[25:21];
        fields_o.va = insn_i[20:16];
        fields_o.vb = insn_i[15:11];
        fields_o.vc = insn_i[10:6];
    end
endmodule

// File: rtl/vmsum_lane.sv
// Module: vmsum_lane
// One lane: two signed halfword products plus a signed word accumulator,
// summed at word+2 bits and clamped to the signed word range.
// Assumes no pipelining inside the lane (purely combinational).
module vmsum_lane #(
    parameter int H = 16
) (
    input  logic [2*H-1:0] a_i,
    input  logic [2*H-1:0] b_i,
    input  logic [2*H-1:0] c_i,
    output logic [2*H-1:0] d_o,
    output logic           clamp_o
);
    localparam int W  = 2 * H;
    localparam int SW = W + 2;
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0]  a0_x, a1_x, b0_x, b1_x;
    logic signed [W-1:0]  prod0, prod1;
    logic signed [SW-1:0] total;
    logic                 ovf;

    // Sign-extend each halfword to word width before multiplying.
    always_comb begin
        a0_x = {{H{a_i[H-1]}},   a_i[H-1:0]};
        a1_x = {{H{a_i[W-1]}},   a_i[W-1:H]};
        b0_x = {{H{b_i[H-1]}},   b_i[H-1:0]};
        b1_x = {{H{b_i[W-1]}},   b_i[W-1:H]};
    end

    // Form both products; each fits in a signed word (max magnitude 2^(2H-2)).
    always_comb begin
        prod0 = a0_x * b0_x;
        prod1 = a1_x * b1_x;
    end

    // Accumulate at word+2 bits so the three-term sum cannot wrap.
    always_comb begin
        total = {{2{prod0[W-1]}}, prod0}
              + {{2{prod1[W-1]}}, prod1}
              + {{2{c_i[W-1]}},   c_i};
    end

    // Clamp when the top three bits disagree; direction from the sign.
    always_comb begin
        ovf     = !((total[SW-1:W-1] == 3'b000) || (total[SW-1:W-1] == 3'b111));
        clamp_o = ovf;
        if (!ovf)
            d_o = total[W-1:0];
        else if (total[SW-1])
            d_o = MINV;
        else
            d_o = MAXV;
    end

    // A clamped lane must sit exactly on one of the two bounds.
    always_comb begin
        if (clamp_o) begin
            AST_CLAMP_BOUND: assert ((d_o == MAXV) || (d_o == MINV)); // R2
        end
    end
endmodule

// File: rtl/vmsum_status.sv
// Module: vmsum_status
// Sticky saturation flag: set by a clamping operation, loaded only by an
// explicit status write; a clamp in the same cycle as a write wins.
module vmsum_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic set_i,
    output logic sat_o
);
    logic sat_q;
    logic sat_d;

    // Next flag value: written value or held value, then OR in a new clamp.
    always_comb begin
        sat_d = (wr_i ? wdata_i : sat_q) | set_i;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_q <= 1'b0;
        else
            sat_q <= sat_d;
    end

    assign sat_o = sat_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && !wr_i) |=> sat_q); // R4

    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_q) |-> ($past(set_i) || ($past(wr_i) && $past(wdata_i)))); // R5
endmodule

// File: rtl/vmsum_unit.sv
// Module: vmsum_unit
// Top of the vector halfword multiply-sum saturating unit. Decodes the
// issued word, runs all lanes in parallel and registers the result one
// cycle later. A disabled vector facility turns a matching issue into a
// fault pulse with no state change. Assumes operands are valid with issue_i.
module vmsum_unit
    import vmsum_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_i,
    input  logic           vec_en_i,
    input  logic [31:0]    insn_i,
    input  logic [VEC-1:0] opa_i,
    input  logic [VEC-1:0] opb_i,
    input  logic [VEC-1:0] opc_i,
    input  logic           sat_wr_i,
    input  logic           sat_wdata_i,
    output logic [VEC-1:0] res_o,
    output logic           res_valid_o,
    output logic [4:0]     res_vd_o,
    output logic           fault_o,
    output logic           sat_o
);
    logic            dec_match;
    vmsum_fields_t   dec_fields;
    logic [VEC-1:0]  lane_res;
    logic [LANES-1:0] lane_clamp;
    logic            exec_go;
    logic            fault_go;
    logic            any_clamp;

    vmsum_decode u_decode (
        .insn_i   (insn_i),
        .match_o  (dec_match),
        .fields_o (dec_fields)
    );

    // One lane instance per 32-bit word of the vector.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vmsum_lane #(.H(HW)) u_lane (
            .a_i     (opa_i[k*WORD +: WORD]),
            .b_i     (opb_i[k*WORD +: WORD]),
            .c_i     (opc_i[k*WORD +: WORD]),
            .d_o     (lane_res[k*WORD +: WORD]),
            .clamp_o (lane_clamp[k])
        );
    end

    // Split a matching issue into execute or fault by the enable input.
    always_comb begin
        exec_go   = issue_i && dec_match && vec_en_i;
        fault_go  = issue_i && dec_match && !vec_en_i;
        any_clamp = exec_go && (|lane_clamp);
    end

    // Result stage: capture lanes and destination only on an execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o       <= '0;
            res_valid_o <= 1'b0;
            res_vd_o    <= '0;
            fault_o     <= 1'b0;
        end else begin
            res_valid_o <= exec_go;
            fault_o     <= fault_go;
            if (exec_go) begin
                res_o    <= lane_res;
                res_vd_o <= dec_fields.vd;
            end
        end
    end

    vmsum_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sat_wr_i),
        .wdata_i (sat_wdata_i),
        .set_i   (any_clamp),
        .sat_o   (sat_o)
    );

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($stable(res_o) && !res_valid_o)); // R6

    AST_FAULT_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_go && !sat_wr_i) |=> $stable(sat_o)); // R6

    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_i && dec_match) |=> (!res_valid_o && !fault_o && $stable(res_o))); // R7
endmodule

// File: tb/sim_vmsum_unit.sv
// Directed bench for vmsum_unit: one task per scenario, each checking itself.
module sim_vmsum_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_i = 1'b0;
    logic         vec_en_i = 1'b1;
    logic [31:0]  insn_i = '0;
    logic [127:0] opa_i = '0, opb_i = '0, opc_i = '0;
    logic         sat_wr_i = 1'b0, sat_wdata_i = 1'b0;
    logic [127:0] res_o;
    logic         res_valid_o, fault_o, sat_o;
    logic [4:0]   res_vd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit model_sat = 0;

    always #4 clk = ~clk;

    vmsum_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .vec_en_i(vec_en_i),
        .insn_i(insn_i), .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i),
        .sat_wr_i(sat_wr_i), .sat_wdata_i(sat_wdata_i),
        .res_o(res_o), .res_valid_o(res_valid_o), .res_vd_o(res_vd_o),
        .fault_o(fault_o), .sat_o(sat_o)
    );

    function automatic logic [31:0] mk_insn(input logic [4:0] vd);
        return {6'd4, vd, 5'd1, 5'd2, 5'd3, 6'd41};
    endfunction

    function automatic logic [31:0] lane_ref(input logic [31:0] a, b, c, output bit s);
        longint t;
        t = longint'($signed(c))
          + longint'($signed(a[15:0]))  * longint'($signed(b[15:0]))
          + longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
        s = 1'b0;
        if (t > 64'sd2147483647) begin s = 1'b1; return 32'h7FFF_FFFF; end
        if (t < -64'sd2147483648) begin s = 1'b1; return 32'h8000_0000; end
        return t[31:0];
    endfunction

    function automatic logic [127:0] vec_ref(input logic [127:0] a, b, c, output bit s);
        logic [127:0] r;
        bit ls;
        s = 1'b0;
        for (int k = 0; k < 4; k++) begin
            r[k*32 +: 32] = lane_ref(a[k*32 +: 32], b[k*32 +: 32], c[k*32 +: 32], ls);
            s = s | ls;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation; after the capturing edge check every output.
    task automatic run_op(input string req, input logic [31:0] insn, input logic en,
                          input logic [127:0] a, b, c);
        logic [127:0] prev, exp;
        bit s, exec;
        prev = res_o;
        exec = (insn[31:26] == 6'd4) && (insn[5:0] == 6'd41);
        exp  = vec_ref(a, b, c, s);
        @(negedge clk);
        issue_i = 1'b1; vec_en_i = en; insn_i = insn;
        opa_i = a; opb_i = b; opc_i = c;
        @(negedge clk);
        issue_i = 1'b0; vec_en_i = 1'b1;
        if (exec && en) begin
            model_sat = model_sat | s;
            check(req, res_o, exp);
            check(req, 128'(res_valid_o), 128'd1);
            check(req, 128'(res_vd_o), 128'(insn[25:21]));
        end else begin
            check(req, res_o, prev);
            check(req, 128'(res_valid_o), 128'd0);
        end
        check(req, 128'(fault_o), 128'(exec && !en));
        check(req, 128'(sat_o), 128'(model_sat));
    endtask

    task automatic write_sat(input logic v);
        @(negedge clk);
        sat_wr_i = 1'b1; sat_wdata_i = v;
        @(negedge clk);
        sat_wr_i = 1'b0;
        model_sat = v;
        check("R5 write", 128'(sat_o), 128'(v));
    endtask

    task automatic t_reset();
        check("R9 res", res_o, '0);
        check("R9 valid", 128'(res_valid_o), 128'd0);
        check("R9 fault", 128'(fault_o), 128'd0);
        check("R9 sat", 128'(sat_o), 128'd0);
    endtask

    task automatic t_basic();
        run_op("R1 R8 basic", mk_insn(5'd7), 1'b1,
               {32'h0003_0002, 32'hFFFF_0002, 32'h7FFF_8000, 32'h0000_0000},
               {32'h0005_0004, 32'h0003_FFFD, 32'h0002_0002, 32'h1234_5678},
               {32'd10, 32'hFFFF_FF00, 32'd5, 32'h8765_4321});
        check("R1 lane3", res_o[127:96], 32'd33);
        check("R1 lane2", res_o[95:64], 32'hFFFF_FEF7);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 24; i++) begin
            logic [127:0] a, b, c;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            if (i % 3 == 0) c = {4{32'h0000_0100}};
            run_op("R1 R2 R4 pattern", mk_insn(5'(i)), 1'b1, a, b, c);
        end
    endtask

    task automatic t_minprod();
        write_sat(1'b0);
        run_op("R3 single min product", mk_insn(5'd1), 1'b1,
               {4{32'h0000_8000}}, {4{32'h0000_8000}}, '0);
        check("R3 value", res_o[31:0], 32'h4000_0000);
        check("R3 no sat", 128'(sat_o), 128'd0);
        run_op("R3 R2 double min product", mk_insn(5'd2), 1'b1,
               {32'h8000_8000, 96'd0}, {32'h8000_8000, 96'd0}, '0);
        check("R3 clamp hi", res_o[127:96], 32'h7FFF_FFFF);
        check("R4 set", 128'(sat_o), 128'd1);
    endtask

    task automatic t_negsat();
        write_sat(1'b0);
        run_op("R2 negative clamp", mk_insn(5'd3), 1'b1,
               {96'd0, 32'h7FFF_7FFF}, {96'd0, 32'h8000_8000}, {96'd0, 32'h8000_0000});
        check("R2 clamp lo", res_o[31:0], 32'h8000_0000);
        run_op("R4 sticky after clean op", mk_insn(5'd4), 1'b1,
               {4{32'h0001_0001}}, {4{32'h0001_0001}}, '0);
        check("R4 sticky", 128'(sat_o), 128'd1);
    endtask

    task automatic t_write_clamp_same();
        write_sat(1'b0);
        @(negedge clk);
        issue_i = 1'b1; insn_i = mk_insn(5'd9); vec_en_i = 1'b1;
        opa_i = {4{32'h7FFF_7FFF}}; opb_i = {4{32'h7FFF_7FFF}}; opc_i = {4{32'h7FFF_FFFF}};
        sat_wr_i = 1'b1; sat_wdata_i = 1'b0;
        @(negedge clk);
        issue_i = 1'b0; sat_wr_i = 1'b0;
        model_sat = 1'b1;
        check("R5 clamp wins over write", 128'(sat_o), 128'd1);
        check("R2 all lanes max", res_o, {4{32'h7FFF_FFFF}});
    endtask

    task automatic t_fault();
        write_sat(1'b0);
        run_op("R6 fault no state change", mk_insn(5'd12), 1'b0,
               {4{32'h8000_8000}}, {4{32'h8000_8000}}, {4{32'h7FFF_FFFF}});
        @(negedge clk);
        check("R6 single pulse", 128'(fault_o), 128'd0);
    endtask

    task automatic t_miss();
        logic [31:0] w;
        w = mk_insn(5'd5); w[5:0] = 6'd40;
        run_op("R7 wrong extended code", w, 1'b1, {4{32'h0005_0005}}, {4{32'h0005_0005}}, '0);
        w = mk_insn(5'd5); w[31:26] = 6'd5;
        run_op("R7 wrong primary code", w, 1'b0, {4{32'h0005_0005}}, {4{32'h0005_0005}}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_patterns();
        t_minprod();
        t_negsat();
        t_write_clamp_same();
        t_fault();
        t_miss();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule